// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for software that has stopped making progress. A 32-bit down-counter runs on the system clock once it is enabled. Each time the counter runs out, it reloads itself with the chosen interval and keeps counting. The interval is one of sixteen powers of two. Software keeps the system alive by writing a fixed key to a restart register, which reloads the counter.

When the counter expires, the block raises an interrupt. What happens next depends on the escalation mode:

- With escalation enabled in two-stage mode, a later expiry that finds the interrupt still pending starts a fixed-width system reset request.
- In direct mode, every expiry starts a reset request.

Each reset request also sets a sticky cause flag. That flag survives the system reset and is cleared only by power-on reset or by software.

The block has two reset inputs:

- A system reset clears everything except the cause flag.
- A power-on reset clears everything, including the cause flag.

The register port is a plain write strobe with a two-bit address and a combinational read.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, `irq`, `rst_req` and `rst_cause` are 0. The control register (address 0) reads 0. The count register (address 1) reads 2^MIN_EXP-1, which is the shortest interval.
- R2: While enable (control bit 0) is 1, the count read at address 1 drops by one each clock. While enable is 0, the count holds.
- R3: Interval select s is held in control bits [7:4]. It gives an expiry every 2^(MIN_EXP+s) clocks. On an expiry the count reloads 2^(MIN_EXP+s)-1 and keeps running.
- R4: An expiry sets the interrupt, which is seen on `irq` and on bit 0 of address 2. Writing 1 to bit 0 of address 2 clears it. An expiry in the same cycle as the clear wins.
- R5: Writing 0x00001984 to address 1 reloads the count with the current interval. Any other value written there leaves the count running unchanged.
- R6: A control write while enable is 1 changes only bit 0. The escalation bit (bit 1), the direct bit (bit 2) and the interval field keep their values. A control write while disabled updates all fields and reloads the count with the newly written interval.
- R7: In two-stage mode (bit 1 = 1, bit 2 = 0), an expiry that finds the interrupt already pending starts a reset request. If software has cleared the interrupt before that expiry, no request is made.
- R8: In direct mode (bit 1 = 1, bit 2 = 1), every expiry starts a reset request.
- R9: With bit 1 = 0, `rst_req` never rises.
- R10: A reset request holds `rst_req` high for exactly PULSE_LEN (4) clocks.
- R11: A reset request sets `rst_cause`, which also reads as bit 0 of address 3. The flag is kept through `sys_rst_n`. It is cleared by `por_n` or by writing 1 to bit 0 of address 3.
- R12: `sys_rst_n` low returns the control register, count, interrupt and reset request to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the cause flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count/restart, 2 interrupt, 3 cause |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Watchdog interrupt, high while pending |
| rst_req | output | 1 | System reset request pulse |
| rst_cause | output | 1 | Sticky flag: the last reset request came from the watchdog |

## Verification
A wrong count register shows up at the count readback at once. At the interrupt output it shows up at the next expiry: the interrupt appears one or more cycles early or late compared with the reference model, which is compared every clock. A wrong pending-interrupt bit turns a serviced expiry into a reset request, or masks a real one. In both cases `rst_req` disagrees with the model within one interval. A wrong pulse counter changes the measured width of the request. A cause flag wrongly wired to the system reset is caught on the first read after a system reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W   = 4;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_IRQ   = 2'd2,
        ADDR_CAUSE = 2'd3
    } wd_addr_e;

    localparam logic [31:0] RESTART_KEY = 32'h0000_1984;

    typedef struct packed {
        logic             en;
        logic             esc_en;
        logic             direct;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output wd_cfg_t           cfg,
    output logic [SEL_W-1:0]  sel_eff,
    output logic              load,
    output logic              irq_clr,
    output logic              cause_clr
);

    wd_cfg_t cfg_d, cfg_q;
    logic    ctrl_wr;
    logic    cfg_load;
    logic    restart;

    always_comb begin
        cfg_d     = cfg_q;
        ctrl_wr   = wr && (addr == ADDR_CTRL);
        cfg_load  = ctrl_wr && !cfg_q.en;
        restart   = wr && (addr == ADDR_COUNT) && (wdata == DATA_W'(RESTART_KEY));
        irq_clr   = wr && (addr == ADDR_IRQ) && wdata[0];
        cause_clr = wr && (addr == ADDR_CAUSE) && wdata[0];
        if (ctrl_wr) begin
            cfg_d.en = wdata[0];
            if (!cfg_q.en) begin
                cfg_d.esc_en = wdata[1];
                cfg_d.direct = wdata[2];
                cfg_d.sel    = wdata[4 +: SEL_W];
            end
        end
        sel_eff = cfg_load ? wdata[4 +: SEL_W] : cfg_q.sel;
        load    = cfg_load || restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    p_locked_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.en |=> ($stable(cfg_q.sel) && $stable(cfg_q.esc_en) && $stable(cfg_q.direct)));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int MIN_EXP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic [CNT_W-1:0] reload_tbl [NUM_SEL];
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_reload
        assign reload_tbl[g] = CNT_W'((64'd1 << (MIN_EXP + g)) - 64'd1);
    end

    always_comb begin
        reload_val = reload_tbl[sel];
        expire     = en && (cnt_q == '0) && !load;
        cnt_d      = cnt_q;
        if (load)              cnt_d = reload_val;
        else if (expire)       cnt_d = reload_val;
        else if (en)           cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= reload_tbl[0];
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(reload_val)));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic expire,
    input  logic esc_en,
    input  logic direct,
    input  logic irq_clr,
    input  logic cause_clr,
    output logic irq,
    output logic rst_req,
    output logic cause
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          irq;
        logic [PW-1:0] pulse;
    } esc_st_t;

    esc_st_t st_d, st_q;
    logic    cause_d, cause_q;
    logic    fire;

    always_comb begin
        st_d    = st_q;
        fire    = expire && esc_en && (direct || st_q.irq);
        if (expire)       st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
        if (fire)                  st_d.pulse = PW'(PULSE_LEN);
        else if (st_q.pulse != '0) st_d.pulse = st_q.pulse - 1'b1;
        cause_d = cause_q;
        if (fire)           cause_d = 1'b1;
        else if (cause_clr) cause_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 1'b0;
        else        cause_q <= cause_d;
    end

    assign irq     = st_q.irq;
    assign rst_req = (st_q.pulse != '0);
    assign cause   = cause_q;

    p_irq_on_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    p_req_needs_esc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(esc_en));

    p_cause_with_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> cause);

    p_pulse_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((PULSE_LEN > 1) && $rose(rst_req)) |=> rst_req);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int MIN_EXP   = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              rst_req,
    output logic              rst_cause
);

    logic             rst_n;
    wd_cfg_t          cfg;
    logic [SEL_W-1:0] sel_eff;
    logic             load;
    logic             irq_clr;
    logic             cause_clr;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign rst_n = por_n & sys_rst_n;

    wdog_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cfg       (cfg),
        .sel_eff   (sel_eff),
        .load      (load),
        .irq_clr   (irq_clr),
        .cause_clr (cause_clr)
    );

    wdog_counter #(.CNT_W(CNT_W), .MIN_EXP(MIN_EXP)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg.en),
        .load   (load),
        .sel    (sel_eff),
        .cnt    (cnt),
        .expire (expire)
    );

    wdog_escalate #(.PULSE_LEN(PULSE_LEN)) u_escalate (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .expire    (expire),
        .esc_en    (cfg.esc_en),
        .direct    (cfg.direct),
        .irq_clr   (irq_clr),
        .cause_clr (cause_clr),
        .irq       (irq),
        .rst_req   (rst_req),
        .cause     (rst_cause)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[0]           = cfg.en;
                reg_rdata[1]           = cfg.esc_en;
                reg_rdata[2]           = cfg.direct;
                reg_rdata[4 +: SEL_W]  = cfg.sel;
            end
            ADDR_COUNT: reg_rdata[CNT_W-1:0] = cnt;
            ADDR_IRQ:   reg_rdata[0]         = irq;
            default:    reg_rdata[0]         = rst_cause;
        endcase
    end

    p_cause_holds_r11: assert property (@(posedge clk) disable iff (!por_n)
        (rst_cause && !(reg_wr && reg_addr == ADDR_CAUSE && reg_wdata[0])) |=> rst_cause);

endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_EXP    = 4;
    localparam int PULSE      = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, rst_req, rst_cause;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int     m_en = 0, m_esc = 0, m_dir = 0, m_sel = 0;
    longint m_cnt = 15;
    int     m_irq = 0, m_pulse = 0, m_cause = 0;
    int     run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_top #(.MIN_EXP(MIN_EXP), .PULSE_LEN(PULSE)) u_wdog_top (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req), .rst_cause(rst_cause)
    );

    function automatic longint reload(int s);
        return (longint'(1) << (MIN_EXP + s)) - 1;
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return 32'(m_en | (m_esc << 1) | (m_dir << 2) | (m_sel << 4));
            2'd1: return 32'(m_cnt);
            2'd2: return 32'(m_irq);
            default: return 32'(m_cause);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            m_en = 0; m_esc = 0; m_dir = 0; m_sel = 0; m_cnt = reload(0);
            m_irq = 0; m_pulse = 0;
            if (!por_n) m_cause = 0;
        end else begin
            bit kick, cfgw, exp_ev, fire;
            int old_irq;
            kick   = reg_wr && reg_addr == 2'd1 && reg_wdata == 32'h1984;
            cfgw   = reg_wr && reg_addr == 2'd0 && m_en == 0;
            exp_ev = m_en != 0 && m_cnt == 0 && !kick && !cfgw;
            old_irq = m_irq;
            fire   = exp_ev && m_esc != 0 && (m_dir != 0 || old_irq != 0);
            if (reg_wr && reg_addr == 2'd0) begin
                if (m_en == 0) begin
                    m_esc = reg_wdata[1]; m_dir = reg_wdata[2]; m_sel = reg_wdata[7:4];
                end
                m_en = reg_wdata[0];
            end
            if (kick || cfgw) m_cnt = reload(m_sel);
            else if (exp_ev) m_cnt = reload(m_sel);
            else if (m_en != 0 && !(reg_wr && reg_addr == 2'd0 && reg_wdata[0] == 0 && 0)) begin
                if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
            if (exp_ev) m_irq = 1;
            else if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) m_irq = 0;
            if (fire) m_pulse = PULSE;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (fire) m_cause = 1;
            else if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) m_cause = 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R4 irq", 32'(irq), 32'(m_irq));
            chk("R7 rst_req", 32'(rst_req), 32'(m_pulse != 0));
            chk("R11 rst_cause", 32'(rst_cause), 32'(m_cause));
        end
    end

    // pulse width measured at the output (R10)
    always @(negedge clk) begin
        if (started && !done) begin
            if (rst_req) run++;
            else if (run > 0) begin
                chk("R10 pulse width", 32'(run), 32'(PULSE));
                run = 0;
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a);
        @(negedge clk); #1;
        reg_addr = a; #1;
        chk(req, reg_rdata, exp_read(a));
    endtask

    task automatic rd_lit(string req, logic [1:0] a, logic [31:0] e);
        @(negedge clk); #1;
        reg_addr = a; #1;
        chk(req, reg_rdata, e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        #1 por_n = 1'b1;
        idle(1);
        started = 1;
        // R1 reset state
        rd_lit("R1 ctrl", 2'd0, 32'h0);
        rd_lit("R1 count", 2'd1, 32'd15);
        rd_lit("R1 cause", 2'd3, 32'h0);
        // R2 hold while disabled
        idle(5);
        rd_lit("R2 hold disabled", 2'd1, 32'd15);
        // enable, interval 0, no escalation (R9)
        wr(2'd0, 32'h1);
        rd_chk("R2 countdown", 2'd1);
        idle(3);
        rd_chk("R2 countdown later", 2'd1);
        idle(60);                       // several expiries; R3 reload via model, R9 no request
        rd_chk("R3 reload value", 2'd1);
        rd_lit("R4 irq pending", 2'd2, 32'h1);
        // R5 restart key
        wr(2'd1, 32'h1985);
        rd_chk("R5 wrong key ignored", 2'd1);
        wr(2'd1, 32'h1984);
        rd_lit("R5 restart", 2'd1, 32'd14);
        // R4 clear
        wr(2'd2, 32'h1);
        rd_lit("R4 cleared", 2'd2, 32'h0);
        // R6 locked fields
        wr(2'd0, 32'hF7);
        rd_lit("R6 locked", 2'd0, 32'h1);
        // disable then two-stage with sel 1 (R7)
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h1);
        wr(2'd0, 32'h13);
        rd_lit("R6 unlocked write", 2'd0, 32'h13);
        rd_chk("R3 new interval load", 2'd1);
        wait_irq();
        wr(2'd2, 32'h1);                // serviced: next expiry must not reset
        wait_irq();
        rd_lit("R7 no reset after service", 2'd3, 32'h0);
        idle(70);                       // left pending: reset requested
        rd_lit("R7 reset after unserviced", 2'd3, 32'h1);
        // R12 system reset keeps cause (R11)
        wr(2'd0, 32'h0);
        idle(8);
        @(negedge clk); #1 sys_rst_n = 1'b0;
        idle(2);
        #1 sys_rst_n = 1'b1;
        rd_lit("R12 ctrl after sysrst", 2'd0, 32'h0);
        rd_lit("R12 count after sysrst", 2'd1, 32'd15);
        rd_lit("R12 irq after sysrst", 2'd2, 32'h0);
        rd_lit("R11 cause survives", 2'd3, 32'h1);
        wr(2'd3, 32'h1);
        rd_lit("R11 cause W1C", 2'd3, 32'h0);
        // R8 direct mode: reset on first expiry
        wr(2'd0, 32'h7);
        idle(20);
        rd_lit("R8 direct reset", 2'd3, 32'h1);
        idle(40);
        wr(2'd0, 32'h0);
        idle(8);
        // R11 power-on reset clears cause
        @(negedge clk); #1 por_n = 1'b0;
        idle(2);
        #1 por_n = 1'b1;
        rd_lit("R11 cause after por", 2'd3, 32'h0);
        rd_lit("R1 ctrl after por", 2'd0, 32'h0);
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule